// File: doc/BRIEF.md
# Thread-Tagged Store Buffer with Load Forwarding and Ordering Gates

This block sits between one processor core and memory and holds retired stores in first-in first-out order until the memory write port accepts them. Several hardware threads share the buffer. Each entry carries an address, a data word and the tag of the thread that issued it. The head entry is offered on a valid/ready write port and leaves when the handshake completes. A new store may enter in the same cycle that the head leaves.

A load presented with its thread tag is checked against every buffered entry. If an entry holds the same address and the same thread tag, the load is answered at once from the youngest such entry. If no entry qualifies, the load is sent on to the memory read port. Stores from another thread are never used to answer a load.

The core asks for two kinds of ordering by holding a request level. While a fence request is held and the buffer is not yet empty, loads are held back. The fence is reported done once nothing is left to drain. An atomic read-modify-write request gets a ready indication only when the buffer is empty, so the load part of the atomic can issue only after every older store has reached memory.

Top module: `tagged_store_buffer`

## Requirements
- R1: Stores appear on the memory write port in exactly the order they were accepted. The head address and data stay stable while `wr_valid` is high and `wr_ready` is low. `wr_valid` is high exactly when the buffer holds at least one entry.
- R2: A load whose address and thread tag both equal those of a buffered entry raises `ld_hit` in the same cycle and returns that entry's data on `ld_data`.
- R3: A buffered entry whose thread tag differs from the load's tag never produces a hit, even when the address matches.
- R4: When several buffered entries match a load's address and tag, `ld_data` comes from the most recently accepted of them.
- R5: A load with no qualifying entry raises `rd_req` with `rd_addr` equal to the load address, and keeps `ld_hit` low. `ld_hit` and `rd_req` are never high together.
- R6: When the buffer holds DEPTH entries, `st_stall` is high and a presented store is not accepted, so it never reaches the write port.
- R7: A store accepted in the same cycle that the head drains leaves the occupancy unchanged. A further acceptance then fills the buffer exactly at DEPTH entries.
- R8: While `fence_req` is high and the buffer is not empty, a presented load gives `ld_wait` high, `ld_hit` low and `rd_req` low. `fence_done` is high exactly when `fence_req` is high and the buffer is empty.
- R9: `rmw_ready` is high exactly when `rmw_req` is high and the buffer is empty, which also means no write is pending on the write port.
- R10: After reset the buffer is empty: `wr_valid`, `st_stall`, `ld_hit` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Retired store presented |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_tid | input | TID_W | Store thread tag |
| st_stall | output | 1 | Buffer full; store not accepted |
| ld_valid | input | 1 | Load presented |
| ld_addr | input | ADDR_W | Load address |
| ld_tid | input | TID_W | Load thread tag |
| ld_hit | output | 1 | Load answered from the buffer |
| ld_data | output | DATA_W | Forwarded data, valid with ld_hit |
| ld_wait | output | 1 | Load held back by a pending fence |
| rd_req | output | 1 | Load sent on to the memory read port |
| rd_addr | output | ADDR_W | Read address |
| wr_valid | output | 1 | Head store offered to memory |
| wr_ready | input | 1 | Memory accepts the head store |
| wr_addr | output | ADDR_W | Head store address |
| wr_data | output | DATA_W | Head store data |
| fence_req | input | 1 | Fence request level |
| fence_done | output | 1 | Fence complete |
| rmw_req | input | 1 | Atomic request level |
| rmw_ready | output | 1 | Atomic load part may issue |

## Verification
A corrupted head pointer or stored field shows up on the next write handshake as a wrong address or data, or as a forwarded value taken from the wrong entry in the cycle a load is presented. An occupancy count that drifts under a simultaneous push and pop makes `st_stall` rise one acceptance early or late. Because every store eventually drains, it also appears as a missing or extra write. In the same cycle it makes `fence_done` or `rmw_ready` rise while stores remain, or never rise. The bench keeps its own queue model and compares every output on every cycle, so most faults appear within a few cycles of their cause.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_HIT  = 2'd1,
        LD_MISS = 2'd2,
        LD_HOLD = 2'd3
    } ld_res_e;
endpackage

// File: rtl/tsb_fwd_search.sv
module tsb_fwd_search #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int TID_W  = 2,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
    input  logic [DEPTH-1:0][TID_W-1:0]  ent_tid,
    input  logic [PTR_W-1:0]             head,
    input  logic [CNT_W-1:0]             count,
    input  logic [ADDR_W-1:0]            q_addr,
    input  logic [TID_W-1:0]             q_tid,
    output logic                         found,
    output logic [DATA_W-1:0]            found_data
);
    // Walk from oldest to youngest; the last match overwrites, so the youngest wins.
    always_comb begin
        found      = 1'b0;
        found_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [PTR_W-1:0] idx;
            idx = head + PTR_W'(i);
            if ((CNT_W'(i) < count) && (ent_addr[idx] == q_addr) && (ent_tid[idx] == q_tid)) begin
                found      = 1'b1;
                found_data = ent_data[idx];
            end
        end
    end
endmodule

// File: rtl/tsb_order_gate.sv
module tsb_order_gate
    import tsb_pkg::*;
(
    input  logic    empty,
    input  logic    fence_req,
    input  logic    rmw_req,
    input  logic    ld_valid,
    input  logic    fwd_found,
    output logic    fence_done,
    output logic    rmw_ready,
    output ld_res_e ld_res
);
    logic fence_hold;

    always_comb begin
        fence_done = fence_req && empty;
        rmw_ready  = rmw_req && empty;
        fence_hold = fence_req && !empty;
        if (!ld_valid)       ld_res = LD_NONE;
        else if (fence_hold) ld_res = LD_HOLD;
        else if (fwd_found)  ld_res = LD_HIT;
        else                 ld_res = LD_MISS;
    end
endmodule

// File: rtl/tagged_store_buffer.sv
module tagged_store_buffer
    import tsb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int TID_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [TID_W-1:0]  st_tid,
    output logic              st_stall,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [TID_W-1:0]  ld_tid,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_wait,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              fence_req,
    output logic              fence_done,
    input  logic              rmw_req,
    output logic              rmw_ready
);
    // DEPTH must be a power of two, at least 2, so pointers wrap naturally.
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][TID_W-1:0]  tid;
        logic [PTR_W-1:0]             head;
        logic [CNT_W-1:0]             count;
    } sb_state_t;

    sb_state_t state_d, state_q;

    logic             full, empty, push, pop;
    logic             fwd_found;
    logic [DATA_W-1:0] fwd_data;
    ld_res_e          ld_res;
    logic [PTR_W-1:0] tail;

    tsb_fwd_search #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W),
        .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_search (
        .ent_addr  (state_q.addr),
        .ent_data  (state_q.data),
        .ent_tid   (state_q.tid),
        .head      (state_q.head),
        .count     (state_q.count),
        .q_addr    (ld_addr),
        .q_tid     (ld_tid),
        .found     (fwd_found),
        .found_data(fwd_data)
    );

    tsb_order_gate u_gate (
        .empty     (empty),
        .fence_req (fence_req),
        .rmw_req   (rmw_req),
        .ld_valid  (ld_valid),
        .fwd_found (fwd_found),
        .fence_done(fence_done),
        .rmw_ready (rmw_ready),
        .ld_res    (ld_res)
    );

    always_comb begin
        full  = (state_q.count == CNT_W'(DEPTH));
        empty = (state_q.count == '0);
        push  = st_valid && !full;
        pop   = !empty && wr_ready;
        tail  = state_q.head + state_q.count[PTR_W-1:0];

        state_d = state_q;
        if (pop) state_d.head = state_q.head + 1'b1;
        if (push) begin
            state_d.addr[tail] = st_addr;
            state_d.data[tail] = st_data;
            state_d.tid[tail]  = st_tid;
        end
        state_d.count = state_q.count + CNT_W'(push) - CNT_W'(pop);

        st_stall = full;
        wr_valid = !empty;
        wr_addr  = state_q.addr[state_q.head];
        wr_data  = state_q.data[state_q.head];
        ld_hit   = (ld_res == LD_HIT);
        ld_data  = ld_hit ? fwd_data : '0;
        ld_wait  = (ld_res == LD_HOLD);
        rd_req   = (ld_res == LD_MISS);
        rd_addr  = ld_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_stall,
    input logic              ld_valid,
    input logic              ld_hit,
    input logic              ld_wait,
    input logic              rd_req,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              fence_req,
    input logic              fence_done,
    input logic              rmw_ready,
    input logic [CNT_W-1:0]  count_q
);
    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    logic acc, drn;
    assign acc = st_valid && !st_stall;
    assign drn = wr_valid && wr_ready;

    // R1
    a_r1_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    // R5
    a_r5_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && rd_req));
    // R6
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
    // R7
    a_r7_count_track: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> count_q == CNT_W'($past(count_q) + CNT_W'($past(acc)) - CNT_W'($past(drn))));
    // R8
    a_r8_fence_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req && wr_valid && ld_valid |-> ld_wait && !ld_hit && !rd_req);
    a_r8_fence_drained: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> !wr_valid);
    // R9
    a_r9_rmw_drained: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_ready |-> !wr_valid);
endmodule

bind tagged_store_buffer tsb_checker #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_tsb_checker (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_stall(st_stall),
    .ld_valid(ld_valid), .ld_hit(ld_hit), .ld_wait(ld_wait), .rd_req(rd_req),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .fence_req(fence_req), .fence_done(fence_done), .rmw_ready(rmw_ready),
    .count_q(state_q.count)
);

// File: tb/tagged_store_buffer_bench.sv
module tagged_store_buffer_bench;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int TID_W  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0, ld_valid = 0, wr_ready = 0, fence_req = 0, rmw_req = 0;
    logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic [TID_W-1:0]  st_tid = '0, ld_tid = '0;
    logic st_stall, ld_hit, ld_wait, rd_req, wr_valid, fence_done, rmw_ready;
    logic [DATA_W-1:0] ld_data, wr_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;

    always #10 clk = ~clk;

    tagged_store_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W))
    u_tagged_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_tid(st_tid),
        .st_stall(st_stall),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tid(ld_tid),
        .ld_hit(ld_hit), .ld_data(ld_data), .ld_wait(ld_wait),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .fence_req(fence_req), .fence_done(fence_done),
        .rmw_req(rmw_req), .rmw_ready(rmw_ready)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference queue: index 0 is the oldest entry
    logic [ADDR_W-1:0] m_addr [DEPTH];
    logic [DATA_W-1:0] m_data [DEPTH];
    logic [TID_W-1:0]  m_tid  [DEPTH];
    int m_cnt = 0;

    logic o_hit, o_stall, o_rd;
    logic [DATA_W-1:0] o_data;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W:0] model_fwd(input logic [ADDR_W-1:0] a, input logic [TID_W-1:0] t);
        logic [DATA_W:0] r;
        r = '0;
        for (int i = 0; i < m_cnt; i++)
            if (m_addr[i] == a && m_tid[i] == t) r = {1'b1, m_data[i]};
        return r;
    endfunction

    task automatic step(input logic sv, input logic [ADDR_W-1:0] sa, input logic [DATA_W-1:0] sd,
                        input logic [TID_W-1:0] stid, input logic lv, input logic [ADDR_W-1:0] la,
                        input logic [TID_W-1:0] ltid, input logic rdy, input logic fen, input logic rmw);
        logic push, pop, hold;
        logic [DATA_W:0] f;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd; st_tid = stid;
        ld_valid = lv; ld_addr = la; ld_tid = ltid;
        wr_ready = rdy; fence_req = fen; rmw_req = rmw;
        #2;
        o_hit = ld_hit; o_data = ld_data; o_stall = st_stall; o_rd = rd_req;
        chk("R1 wr_valid", 64'(wr_valid), 64'(m_cnt > 0));
        if (m_cnt > 0) begin
            chk("R1 wr_addr", 64'(wr_addr), 64'(m_addr[0]));
            chk("R1 wr_data", 64'(wr_data), 64'(m_data[0]));
        end
        chk("R6 st_stall", 64'(st_stall), 64'(m_cnt == DEPTH));
        chk("R8 fence_done", 64'(fence_done), 64'(fen && m_cnt == 0));
        chk("R9 rmw_ready", 64'(rmw_ready), 64'(rmw && m_cnt == 0));
        hold = fen && m_cnt > 0;
        f = model_fwd(la, ltid);
        chk("R8 ld_wait", 64'(ld_wait), 64'(lv && hold));
        chk("R2 ld_hit", 64'(ld_hit), 64'(lv && !hold && f[DATA_W]));
        if (lv && !hold && f[DATA_W]) chk("R2 ld_data", 64'(ld_data), 64'(f[DATA_W-1:0]));
        chk("R5 rd_req", 64'(rd_req), 64'(lv && !hold && !f[DATA_W]));
        if (rd_req) chk("R5 rd_addr", 64'(rd_addr), 64'(la));
        push = sv && m_cnt < DEPTH;
        pop  = rdy && m_cnt > 0;
        @(posedge clk);
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                m_addr[i] = m_addr[i+1]; m_data[i] = m_data[i+1]; m_tid[i] = m_tid[i+1];
            end
            m_cnt--;
        end
        if (push) begin
            m_addr[m_cnt] = sa; m_data[m_cnt] = sd; m_tid[m_cnt] = stid;
            m_cnt++;
        end
    endtask

    task automatic idle(input logic rdy);
        step(0, '0, '0, '0, 0, '0, '0, rdy, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        // R10 reset state
        @(negedge clk);
        chk("R10 wr_valid", 64'(wr_valid), 64'd0);
        chk("R10 st_stall", 64'(st_stall), 64'd0);
        chk("R10 ld_hit", 64'(ld_hit), 64'd0);
        chk("R10 rd_req", 64'(rd_req), 64'd0);

        // R4 youngest match wins; R3 other thread not forwarded
        step(1, 16'h5, 32'hAAAA0001, 2'd1, 0, '0, '0, 0, 0, 0);
        step(1, 16'h5, 32'hBBBB0002, 2'd2, 0, '0, '0, 0, 0, 0);
        step(1, 16'h5, 32'hCCCC0003, 2'd1, 0, '0, '0, 0, 0, 0);
        step(0, '0, '0, '0, 1, 16'h5, 2'd1, 0, 0, 0);
        chk("R4 youngest", 64'(o_data), 64'h0000_0000_CCCC_0003);
        step(0, '0, '0, '0, 1, 16'h5, 2'd3, 0, 0, 0);
        chk("R3 no cross-thread hit", 64'(o_hit), 64'd0);
        chk("R3 sent to memory", 64'(o_rd), 64'd1);

        // R7 push+pop at count 3, then one push reaches full; R6 drop while full
        step(1, 16'h7, 32'h7, 2'd0, 0, '0, '0, 1, 0, 0);   // 3 -> 3
        chk("R7 not full after swap", 64'(o_stall), 64'd0);
        step(1, 16'h8, 32'h8, 2'd0, 0, '0, '0, 0, 0, 0);   // 3 -> 4
        step(1, 16'h9, 32'hDEAD, 2'd0, 0, '0, '0, 0, 0, 0); // dropped
        chk("R6 stall when full", 64'(o_stall), 64'd1);
        chk("R7 full after one more", 64'(m_cnt), 64'(DEPTH));

        // R8 fence holds loads until drained
        step(0, '0, '0, '0, 1, 16'h7, 2'd0, 0, 1, 1);
        chk("R8 load held", 64'(o_hit | o_rd), 64'd0);
        while (m_cnt > 0) step(0, '0, '0, '0, 1, 16'h7, 2'd0, 1, 1, 1);
        step(0, '0, '0, '0, 1, 16'h7, 2'd0, 0, 1, 1);
        chk("R8 load released after done", 64'(o_rd), 64'd1);

        // randomized mix
        for (int c = 0; c < 3000; c++) begin
            step(($urandom % 3) != 0, ADDR_W'($urandom % 4), $urandom, TID_W'($urandom % 2),
                 ($urandom % 2) == 1, ADDR_W'($urandom % 4), TID_W'($urandom % 2),
                 ($urandom % 3) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0);
        end
        while (m_cnt > 0) idle(1);
        idle(0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule